// File: doc/BRIEF.md
# Staged-Write Memory Command Engine

This block is the byte-level command layer of a serial slave memory. A bit-level transport in front of it delivers each received byte with a one-cycle strobe. It asks for a reply byte with a one-cycle request and signals when the master has pulsed a bus reset. Every transaction starts after a bus reset. The first byte must be the skip-addressing code CCh. The next byte then picks one of four memory functions.

Writes never reach the array directly. The master first fills a 32-byte staging buffer at a 16-bit target address. It can read the buffer back together with its address and status bytes. The commit command copies the buffer into the array, but only if the master repeats those three bytes exactly. While the commit runs, and after it ends, the engine replies with zero bytes. A plain memory read streams array data from any address. It returns all-ones bytes past the top of the array, whose size is set by `MEM_AW` (2048 bytes by default, 13 bits for 8192 bytes).

The status byte is laid out as follows: bit 7 is the commit-accepted flag, bit 5 is the torn-byte flag, bit 6 reads 0, and bits 4:0 hold the last written offset. The beginning offset is the low five bits of the first address byte.

Top module: `scratch_cmd_engine`

## Requirements
- R1: After reset, and in every state other than a reply phase, a read request returns FFh. A first byte after bus reset that is not CCh makes the engine ignore all further bytes until the next bus reset. After reset, staging-buffer reads show address 0000h and status 00h.
- R2: Command 0Fh takes a low address byte and then a high address byte. Data bytes then fill the buffer from the beginning offset (address bits 4:0) upward, and the status offset field tracks the last byte stored.
- R3: Data bytes after offset 31 has been written are discarded, and the offset field stays at 1Fh.
- R4: Command AAh replies with the low address byte, the high address byte and the status byte. It then returns the buffer from the beginning offset through the ending offset, and FFh after that.
- R5: Command 55h followed by the low address byte, the high address byte and the status byte, all matching, sets status bit 7. It then copies buffer offsets beginning..ending to array address {addr[15:5], offset}.
- R6: If any of the three echoed bytes differs, nothing is copied, status bit 7 is not set, and reads return FFh until bus reset.
- R7: During the copy (`COPY_CYCLES` cycles) and after it, read requests return 00h. A bus reset during the copy is ignored, and a bus reset after it returns the engine to idle.
- R8: Status bit 7 stays set through buffer reads and array reads and is cleared only by command 0Fh.
- R9: Command F0h takes two address bytes and streams array bytes from that address upward, returning FFh past the array top. The address registers keep the supplied address, and the status byte is unchanged.
- R10: A bus reset outside a copy aborts the current command. If it arrives with `rx_partial` high during 0Fh data, status bit 5 is set and the offset field moves to the torn byte's slot, whose content is kept.
- R11: Every read request is answered with `tx_valid` and the reply byte in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rst | input | 1 | One-cycle pulse: master issued a bus reset |
| rx_partial | input | 1 | With `bus_rst`: an unfinished byte was being received |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Master wants a reply byte |
| tx_valid | output | 1 | Reply byte valid (one cycle after `tx_req`) |
| tx_byte | output | 8 | Reply byte |

## Verification
The bench echoes the status byte after a two-byte write and checks that the commit then copies exactly those bytes. A wrong byte in the echo must leave the array unchanged, which catches a design that compares only part of the authorization. A bus reset pulsed in the middle of the copy must not cut the zero stream short. A write that runs off the page end must stop at offset 31 and not wrap onto offset 0. A read that crosses the array top must turn into FFh bytes and not wrap around to address zero. A torn byte at bus reset must set bit 5 and extend the offset field without changing the byte's stored value.

// File: rtl/scratch_cmd_engine.sv
module scratch_cmd_engine #(
  parameter int MEM_AW      = 11,
  parameter int COPY_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       rx_partial,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_req,
  output logic       tx_valid,
  output logic [7:0] tx_byte
);
  localparam int MEM_BYTES = 1 << MEM_AW;
  localparam int CW = $clog2(COPY_CYCLES + 1);

  localparam logic [3:0] S_ROM = 4'd0, S_FUNC = 4'd1, S_WTA1 = 4'd2, S_WTA2 = 4'd3,
                         S_WDAT = 4'd4, S_RSP = 4'd5, S_CA1 = 4'd6, S_CA2 = 4'd7,
                         S_CES = 4'd8, S_BUSY = 4'd9, S_DONE = 4'd10, S_MTA1 = 4'd11,
                         S_MTA2 = 4'd12, S_MDAT = 4'd13, S_HALT = 4'd14;

  logic [3:0]    state;
  logic [15:0]   ta;
  logic          aa, pf, auth_ok;
  logic [4:0]    eoff;
  logic [5:0]    idx;
  logic [1:0]    phase;
  logic [CW-1:0] busy_cnt;
  logic [16:0]   maddr;
  logic [7:0]    sp [32];
  logic [7:0]    mem [MEM_BYTES];
  logic [7:0]    rd_data;

  wire [7:0]  es      = {aa, 1'b0, pf, eoff};
  wire        in_span = idx <= {1'b0, eoff};
  wire [15:0] mem_wa  = {ta[15:5], idx[4:0]};
  wire        mem_we  = (state == S_BUSY) && in_span && (32'(mem_wa) < MEM_BYTES);

  always_ff @(posedge clk)
    if (mem_we) mem[mem_wa[MEM_AW-1:0]] <= sp[idx[4:0]];

  always_comb begin
    rd_data = 8'hFF;
    case (state)
      S_RSP: case (phase)
        2'd0:    rd_data = ta[7:0];
        2'd1:    rd_data = ta[15:8];
        2'd2:    rd_data = es;
        default: rd_data = in_span ? sp[idx[4:0]] : 8'hFF;
      endcase
      S_BUSY, S_DONE: rd_data = 8'h00;
      S_MDAT: if (32'(maddr) < MEM_BYTES) rd_data = mem[maddr[MEM_AW-1:0]];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= 8'hFF;
    end else begin
      tx_valid <= tx_req;
      if (tx_req) tx_byte <= rd_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_ROM;
      ta       <= '0;
      aa       <= 1'b0;
      pf       <= 1'b0;
      auth_ok  <= 1'b0;
      eoff     <= '0;
      idx      <= '0;
      phase    <= '0;
      busy_cnt <= '0;
      maddr    <= '0;
      for (int i = 0; i < 32; i++) sp[i] <= 8'h00;
    end else if (bus_rst && state != S_BUSY) begin
      state <= S_ROM;
      if (state == S_WDAT && rx_partial) begin
        pf <= 1'b1;
        if (!idx[5]) eoff <= idx[4:0];
      end
    end else begin
      case (state)
        S_ROM: if (rx_valid) state <= (rx_byte == 8'hCC) ? S_FUNC : S_HALT;
        S_FUNC: if (rx_valid)
          case (rx_byte)
            8'h0F: begin aa <= 1'b0; pf <= 1'b0; state <= S_WTA1; end
            8'hAA: begin phase <= '0; idx <= {1'b0, ta[4:0]}; state <= S_RSP; end
            8'h55: begin auth_ok <= 1'b1; state <= S_CA1; end
            8'hF0: state <= S_MTA1;
            default: state <= S_HALT;
          endcase
        S_WTA1: if (rx_valid) begin ta[7:0] <= rx_byte; state <= S_WTA2; end
        S_WTA2: if (rx_valid) begin
          ta[15:8] <= rx_byte;
          eoff     <= ta[4:0];
          idx      <= {1'b0, ta[4:0]};
          state    <= S_WDAT;
        end
        S_WDAT: if (rx_valid && !idx[5]) begin
          sp[idx[4:0]] <= rx_byte;
          eoff         <= idx[4:0];
          idx          <= idx + 6'd1;
        end
        S_RSP: if (tx_req) begin
          if (phase != 2'd3) phase <= phase + 2'd1;
          else if (in_span)  idx <= idx + 6'd1;
        end
        S_CA1: if (rx_valid) begin auth_ok <= auth_ok && rx_byte == ta[7:0];  state <= S_CA2; end
        S_CA2: if (rx_valid) begin auth_ok <= auth_ok && rx_byte == ta[15:8]; state <= S_CES; end
        S_CES: if (rx_valid) begin
          if (auth_ok && rx_byte == es) begin
            aa       <= 1'b1;
            idx      <= {1'b0, ta[4:0]};
            busy_cnt <= '0;
            state    <= S_BUSY;
          end else state <= S_HALT;
        end
        S_BUSY: begin
          if (in_span) idx <= idx + 6'd1;
          busy_cnt <= busy_cnt + 1'b1;
          if (busy_cnt == CW'(COPY_CYCLES - 1)) state <= S_DONE;
        end
        S_MTA1: if (rx_valid) begin ta[7:0] <= rx_byte; state <= S_MTA2; end
        S_MTA2: if (rx_valid) begin
          ta[15:8] <= rx_byte;
          maddr    <= {1'b0, rx_byte, ta[7:0]};
          state    <= S_MDAT;
        end
        S_MDAT: if (tx_req && 32'(maddr) < MEM_BYTES) maddr <= maddr + 17'd1;
        default: ;
      endcase
    end
endmodule

// File: rtl/scratch_cmd_engine_chk.sv
module scratch_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rst,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic       tx_req,
  input logic       tx_valid,
  input logic [7:0] tx_byte,
  input logic [3:0] state,
  input logic [7:0] es
);
  // R11
  reply_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> tx_valid);
  // R7
  copy_zero_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd9 || state == 4'd10) && tx_req |=> tx_byte == 8'h00);
  // R7
  copy_ignores_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd9 && bus_rst |=> (state == 4'd9 || state == 4'd10));
  // R8
  aa_cleared_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd1 && rx_valid && rx_byte == 8'h0F |=> !es[7]);
  // R5
  aa_set_by_auth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(es[7]) |-> $past(state) == 4'd8);
  // R1
  halted_reply_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd14 && tx_req |=> tx_byte == 8'hFF);
endmodule

bind scratch_cmd_engine scratch_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
  .rx_byte(rx_byte), .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .state(state), .es(es)
);

// File: tb/test_scratch_cmd_engine.sv
module test_scratch_cmd_engine;
  logic clk = 1'b0, rst_n = 1'b0, bus_rst = 1'b0, rx_partial = 1'b0;
  logic rx_valid = 1'b0, tx_req = 1'b0, tx_valid;
  logic [7:0] rx_byte = 8'h00, tx_byte;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  scratch_cmd_engine i_scratch_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_partial(rx_partial),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
    .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [7:0] exp);
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
    chk("R11", {7'd0, tx_valid}, 8'h01);
    chk(req, tx_byte, exp);
  endtask

  task automatic breset(input logic partial);
    @(negedge clk); bus_rst = 1'b1; rx_partial = partial;
    @(negedge clk); bus_rst = 1'b0; rx_partial = 1'b0;
  endtask

  task automatic t_reset_state;
    expect_rd("R1", 8'hFF);
    send(8'h0F); send(8'hCC); send(8'hAA);
    expect_rd("R1", 8'hFF);
    breset(1'b0);
    send(8'hCC); send(8'hAA);
    expect_rd("R1", 8'h00); expect_rd("R1", 8'h00); expect_rd("R1", 8'h00);
  endtask

  task automatic t_write_read;
    breset(1'b0);
    send(8'hCC); send(8'h0F); send(8'h26); send(8'h00); send(8'hA1); send(8'hB2);
    breset(1'b0);
    send(8'hCC); send(8'hAA);
    expect_rd("R4", 8'h26); expect_rd("R4", 8'h00); expect_rd("R2", 8'h07);
    expect_rd("R2", 8'hA1); expect_rd("R2", 8'hB2); expect_rd("R4", 8'hFF);
  endtask

  task automatic t_copy;
    breset(1'b0);
    send(8'hCC); send(8'h55); send(8'h26); send(8'h00); send(8'h07);
    expect_rd("R7", 8'h00);
    breset(1'b0);
    expect_rd("R7", 8'h00);
    repeat (50) @(negedge clk);
    expect_rd("R7", 8'h00);
    breset(1'b0);
    send(8'hCC); send(8'hF0); send(8'h26); send(8'h00);
    expect_rd("R5", 8'hA1); expect_rd("R5", 8'hB2);
    breset(1'b0);
    send(8'hCC); send(8'hAA);
    expect_rd("R5", 8'h26); expect_rd("R5", 8'h00); expect_rd("R5", 8'h87);
  endtask

  task automatic t_aa_sticky;
    breset(1'b0);
    send(8'hCC); send(8'hF0); send(8'h27); send(8'h00);
    expect_rd("R9", 8'hB2);
    breset(1'b0);
    send(8'hCC); send(8'hAA);
    expect_rd("R9", 8'h27); expect_rd("R9", 8'h00); expect_rd("R8", 8'h87);
    expect_rd("R4", 8'hB2); expect_rd("R4", 8'hFF);
    breset(1'b0);
    send(8'hCC); send(8'h0F); send(8'h40); send(8'h00); send(8'hC3);
    breset(1'b0);
    send(8'hCC); send(8'hAA);
    expect_rd("R8", 8'h40); expect_rd("R8", 8'h00); expect_rd("R8", 8'h00);
    expect_rd("R8", 8'hC3); expect_rd("R8", 8'hFF);
  endtask

  task automatic t_mismatch;
    breset(1'b0);
    send(8'hCC); send(8'h0F); send(8'h26); send(8'h00); send(8'h5A);
    breset(1'b0);
    send(8'hCC); send(8'h55); send(8'h26); send(8'h00); send(8'h07);
    expect_rd("R6", 8'hFF);
    repeat (50) @(negedge clk);
    breset(1'b0);
    send(8'hCC); send(8'hF0); send(8'h26); send(8'h00);
    expect_rd("R6", 8'hA1);
    breset(1'b0);
    send(8'hCC); send(8'hAA);
    expect_rd("R6", 8'h26); expect_rd("R6", 8'h00); expect_rd("R6", 8'h06);
    expect_rd("R6", 8'h5A);
  endtask

  task automatic t_overrun_top;
    breset(1'b0);
    send(8'hCC); send(8'h0F); send(8'hFE); send(8'h07);
    send(8'h11); send(8'h22); send(8'h33);
    breset(1'b0);
    send(8'hCC); send(8'hAA);
    expect_rd("R3", 8'hFE); expect_rd("R3", 8'h07); expect_rd("R3", 8'h1F);
    expect_rd("R3", 8'h11); expect_rd("R3", 8'h22); expect_rd("R3", 8'hFF);
    breset(1'b0);
    send(8'hCC); send(8'h55); send(8'hFE); send(8'h07); send(8'h1F);
    repeat (50) @(negedge clk);
    breset(1'b0);
    send(8'hCC); send(8'hF0); send(8'hFE); send(8'h07);
    expect_rd("R9", 8'h11); expect_rd("R9", 8'h22);
    expect_rd("R9", 8'hFF); expect_rd("R9", 8'hFF);
  endtask

  task automatic t_partial_abort;
    breset(1'b0);
    send(8'hCC); send(8'h0F); send(8'h03); send(8'h01); send(8'h44);
    breset(1'b1);
    send(8'hCC); send(8'hAA);
    expect_rd("R10", 8'h03); expect_rd("R10", 8'h01); expect_rd("R10", 8'h24);
    expect_rd("R10", 8'h44); expect_rd("R10", 8'h00); expect_rd("R10", 8'hFF);
    breset(1'b0);
    send(8'hCC); send(8'hF0); send(8'h26); send(8'h00);
    expect_rd("R10", 8'hA1);
    breset(1'b0);
    expect_rd("R10", 8'hFF);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog got=timeout exp=done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_write_read();
    t_copy();
    t_aa_sticky();
    t_mismatch();
    t_overrun_top();
    t_partial_abort();
    summary();
  end
endmodule